// File: doc/BRIEF.md
# Dual-Port Synchronous Byte-Lane RAM

This block is a true dual-port static RAM of 16-bit words. Each of its two ports runs on its own clock and has its own address, data and control inputs. Either port can reach any word, and both ports may work on the same word in the same cycle. All controls are sampled on the rising clock edge. The one exception is the active-low output enable, which gates the read drive with no clock. Each 16-bit word is split into two byte lanes. An active-low byte select controls each lane, for both writes and reads.

A static mode input on each port chooses between two read timings. In flow-through mode the word read appears just after the edge that captured its address. In pipelined mode a register adds one cycle. In pipelined mode the chip enables pass through two register stages, so turning the port's drive off or back on takes two cycles. The byte selects always pass through one stage. There are no tri-states in the model: each port gives its read word and one drive flag per lane, and an undriven lane reads as zero.

The memory has parameterized depth. Because the ports are in separate clock domains, each port writes into its own copy of the storage. A one-bit tag per word and per lane records which copy was written last.

Top module: `dpram_bytelane`

## Requirements
- R1: A port is selected when ce0_n is 0 and ce1 is 1. A port whose controls were deselected at an edge (ce0_n 1 or ce1 0) drives neither lane after that edge in flow-through mode. Both drive flags are 0 after reset.
- R2: A selected cycle with we_n 0 writes bits 15:8 only when ub_n is 0 and bits 7:0 only when lb_n is 0. A lane whose select is 1 keeps its previous contents.
- R3: During reads, the upper lane (bits 15:8, flag drv_hi) drives only when ub_n was 0 at the most recent edge, and the lower lane (bits 7:0, flag drv_lo) only when lb_n was 0. This holds in both modes. An undriven lane reads as zero.
- R4: In flow-through mode (pipe input 0), a read captured at an edge gives the word at that address right after the same edge.
- R5: In pipelined mode (pipe input 1), a read captured at an edge gives its word right after the following edge.
- R6: In pipelined mode, a change of chip enable reaches the drive flags after two edges. After deselection the port still drives for one more cycle. After reselection it stays quiet for one cycle.
- R7: Output enable is asynchronous. While oe_n is 1 both drive flags are 0 at once, and they return as soon as oe_n goes back to 0.
- R8: A word written by one port is returned by a read of that address on the other port at any later edge.
- R9: A write cycle returns no read data. After the edge that registers a write, the port's drive flags are 0 (flow-through), or 0 one cycle later (pipelined).
- R10: Each port keeps its own mode, and one port in flow-through mode and the other in pipelined mode work at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A asynchronous reset, active low |
| a_pipe | input | 1 | Port A read mode: 0 flow-through, 1 pipelined (static) |
| a_ce0_n | input | 1 | Port A chip enable, active low |
| a_ce1 | input | 1 | Port A chip enable, active high |
| a_we_n | input | 1 | Port A write strobe, low writes, high reads |
| a_ub_n | input | 1 | Port A upper-lane select, active low |
| a_lb_n | input | 1 | Port A lower-lane select, active low |
| a_oe_n | input | 1 | Port A asynchronous output enable, active low |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | 16 | Port A write word |
| a_rdata | output | 16 | Port A read word, zero on undriven lanes |
| a_drv_hi | output | 1 | Port A upper lane driving |
| a_drv_lo | output | 1 | Port A lower lane driving |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B asynchronous reset, active low |
| b_pipe | input | 1 | Port B read mode: 0 flow-through, 1 pipelined (static) |
| b_ce0_n | input | 1 | Port B chip enable, active low |
| b_ce1 | input | 1 | Port B chip enable, active high |
| b_we_n | input | 1 | Port B write strobe, low writes, high reads |
| b_ub_n | input | 1 | Port B upper-lane select, active low |
| b_lb_n | input | 1 | Port B lower-lane select, active low |
| b_oe_n | input | 1 | Port B asynchronous output enable, active low |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | 16 | Port B write word |
| b_rdata | output | 16 | Port B read word, zero on undriven lanes |
| b_drv_hi | output | 1 | Port B upper lane driving |
| b_drv_lo | output | 1 | Port B lower lane driving |

## Verification
The bench builds the block with ADDR_W set to 6, which gives 64 words. With so few words, a fill pass covers every word and random masked writes hit the same words many times. This exercises the per-lane tags that decide which port's copy is current. Port A runs in flow-through mode and port B in pipelined mode, so the two latencies and the one-stage and two-stage enable paths are observed in the same run. The cross-port reads then check that the tags pick the newer copy in both directions.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;

    typedef enum logic {
        MODE_FLOW = 1'b0,
        MODE_PIPE = 1'b1
    } rd_mode_e;

    // active-low lane selects {upper, lower} -> active-high lane enables
    function automatic logic [LANES-1:0] lane_enables(input logic up_n, input logic lo_n);
        return {~up_n, ~lo_n};
    endfunction
endpackage

// File: rtl/dpr_port.sv
module dpr_port
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pipe,
    input  logic                ce0_n,
    input  logic                ce1,
    input  logic                we_n,
    input  logic                ub_n,
    input  logic                lb_n,
    input  logic                oe_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [WORD_W-1:0]   wdata,
    input  logic [WORD_W-1:0]   arr_rdata,
    output logic                arr_we,
    output logic [LANES-1:0]    arr_be,
    output logic [ADDR_W-1:0]   arr_waddr,
    output logic [WORD_W-1:0]   arr_wdata,
    output logic [ADDR_W-1:0]   arr_raddr,
    output logic [WORD_W-1:0]   rdata,
    output logic [LANES-1:0]    drv
);
    typedef struct packed {
        logic               rd1;   // selected read, one stage
        logic               rd2;   // selected read, two stages
        logic [LANES-1:0]   lane;  // lane enables, one stage
        logic [WORD_W-1:0]  pdat;  // pipelined read word
        logic [ADDR_W-1:0]  addr;  // captured address
    } st_t;

    st_t      st_d, st_q;
    rd_mode_e mode;
    logic     sel_now;
    logic     active;

    assign mode = rd_mode_e'(pipe);

    always_comb begin
        sel_now   = !ce0_n && ce1;
        arr_we    = sel_now && !we_n;
        arr_be    = lane_enables(ub_n, lb_n);
        arr_waddr = addr;
        arr_wdata = wdata;
        arr_raddr = st_q.addr;

        st_d      = st_q;
        st_d.rd1  = sel_now && we_n;
        st_d.rd2  = st_q.rd1;
        st_d.lane = lane_enables(ub_n, lb_n);
        st_d.pdat = arr_rdata;
        st_d.addr = addr;

        active = (mode == MODE_PIPE) ? st_q.rd2 : st_q.rd1;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_out
        logic [LANE_W-1:0] src;
        assign src = (mode == MODE_PIPE) ? st_q.pdat[l*LANE_W +: LANE_W]
                                         : arr_rdata[l*LANE_W +: LANE_W];
        assign drv[l] = active && st_q.lane[l] && !oe_n;
        assign rdata[l*LANE_W +: LANE_W] = drv[l] ? src : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dpr_array.sv
module dpr_array
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic                clk_a,
    input  logic                we_a,
    input  logic [LANES-1:0]    be_a,
    input  logic [ADDR_W-1:0]   waddr_a,
    input  logic [WORD_W-1:0]   wdata_a,
    input  logic [ADDR_W-1:0]   raddr_a,
    output logic [WORD_W-1:0]   rdata_a,
    input  logic                clk_b,
    input  logic                we_b,
    input  logic [LANES-1:0]    be_b,
    input  logic [ADDR_W-1:0]   waddr_b,
    input  logic [WORD_W-1:0]   wdata_b,
    input  logic [ADDR_W-1:0]   raddr_b,
    output logic [WORD_W-1:0]   rdata_b
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem_a [DEPTH];
        logic [LANE_W-1:0] mem_b [DEPTH];
        logic              tag_a [DEPTH];
        logic              tag_b [DEPTH];

        // equal tags: copy A is newest; different tags: copy B is newest
        always_ff @(posedge clk_a) begin
            if (we_a && be_a[l]) begin
                mem_a[waddr_a] <= wdata_a[l*LANE_W +: LANE_W];
                tag_a[waddr_a] <= tag_b[waddr_a];
            end
        end

        always_ff @(posedge clk_b) begin
            if (we_b && be_b[l]) begin
                mem_b[waddr_b] <= wdata_b[l*LANE_W +: LANE_W];
                tag_b[waddr_b] <= ~tag_a[waddr_b];
            end
        end

        assign rdata_a[l*LANE_W +: LANE_W] = (tag_a[raddr_a] == tag_b[raddr_a])
                                             ? mem_a[raddr_a] : mem_b[raddr_a];
        assign rdata_b[l*LANE_W +: LANE_W] = (tag_a[raddr_b] == tag_b[raddr_b])
                                             ? mem_a[raddr_b] : mem_b[raddr_b];
    end
endmodule

// File: rtl/dpram_bytelane.sv
module dpram_bytelane
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic                clk_a,
    input  logic                rst_a_n,
    input  logic                a_pipe,
    input  logic                a_ce0_n,
    input  logic                a_ce1,
    input  logic                a_we_n,
    input  logic                a_ub_n,
    input  logic                a_lb_n,
    input  logic                a_oe_n,
    input  logic [ADDR_W-1:0]   a_addr,
    input  logic [WORD_W-1:0]   a_wdata,
    output logic [WORD_W-1:0]   a_rdata,
    output logic                a_drv_hi,
    output logic                a_drv_lo,
    input  logic                clk_b,
    input  logic                rst_b_n,
    input  logic                b_pipe,
    input  logic                b_ce0_n,
    input  logic                b_ce1,
    input  logic                b_we_n,
    input  logic                b_ub_n,
    input  logic                b_lb_n,
    input  logic                b_oe_n,
    input  logic [ADDR_W-1:0]   b_addr,
    input  logic [WORD_W-1:0]   b_wdata,
    output logic [WORD_W-1:0]   b_rdata,
    output logic                b_drv_hi,
    output logic                b_drv_lo
);
    logic                we_a, we_b;
    logic [LANES-1:0]    be_a, be_b, drv_a, drv_b;
    logic [ADDR_W-1:0]   waddr_a, waddr_b, raddr_a, raddr_b;
    logic [WORD_W-1:0]   wdat_a, wdat_b, rword_a, rword_b;

    dpr_port #(.ADDR_W(ADDR_W)) u_pa (
        .clk(clk_a), .rst_n(rst_a_n), .pipe(a_pipe),
        .ce0_n(a_ce0_n), .ce1(a_ce1), .we_n(a_we_n),
        .ub_n(a_ub_n), .lb_n(a_lb_n), .oe_n(a_oe_n),
        .addr(a_addr), .wdata(a_wdata), .arr_rdata(rword_a),
        .arr_we(we_a), .arr_be(be_a), .arr_waddr(waddr_a),
        .arr_wdata(wdat_a), .arr_raddr(raddr_a),
        .rdata(a_rdata), .drv(drv_a)
    );

    dpr_port #(.ADDR_W(ADDR_W)) u_pb (
        .clk(clk_b), .rst_n(rst_b_n), .pipe(b_pipe),
        .ce0_n(b_ce0_n), .ce1(b_ce1), .we_n(b_we_n),
        .ub_n(b_ub_n), .lb_n(b_lb_n), .oe_n(b_oe_n),
        .addr(b_addr), .wdata(b_wdata), .arr_rdata(rword_b),
        .arr_we(we_b), .arr_be(be_b), .arr_waddr(waddr_b),
        .arr_wdata(wdat_b), .arr_raddr(raddr_b),
        .rdata(b_rdata), .drv(drv_b)
    );

    dpr_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk_a(clk_a), .we_a(we_a), .be_a(be_a), .waddr_a(waddr_a),
        .wdata_a(wdat_a), .raddr_a(raddr_a), .rdata_a(rword_a),
        .clk_b(clk_b), .we_b(we_b), .be_b(be_b), .waddr_b(waddr_b),
        .wdata_b(wdat_b), .raddr_b(raddr_b), .rdata_b(rword_b)
    );

    assign a_drv_hi = drv_a[1];
    assign a_drv_lo = drv_a[0];
    assign b_drv_hi = drv_b[1];
    assign b_drv_lo = drv_b[0];
endmodule

// File: rtl/dpram_bytelane_chk.sv
module dpram_bytelane_chk (
    input logic clk_a,
    input logic rst_a_n,
    input logic a_pipe,
    input logic a_ce0_n,
    input logic a_ce1,
    input logic a_we_n,
    input logic a_ub_n,
    input logic a_oe_n,
    input logic a_drv_hi,
    input logic a_drv_lo,
    input logic clk_b,
    input logic rst_b_n,
    input logic b_pipe,
    input logic b_ce0_n,
    input logic b_ce1,
    input logic b_oe_n,
    input logic b_drv_hi,
    input logic b_drv_lo
);
    AST_FLOW_DESEL_QUIET: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (!a_pipe && !(!a_ce0_n && a_ce1)) |=> (!a_drv_hi && !a_drv_lo)); // R1

    AST_UPPER_SEL_ONCE: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        a_ub_n |=> !a_drv_hi); // R3

    AST_OE_GATES_A: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        a_oe_n |-> (!a_drv_hi && !a_drv_lo)); // R7

    AST_OE_GATES_B: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        b_oe_n |-> (!b_drv_hi && !b_drv_lo)); // R7

    AST_FLOW_WRITE_QUIET: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (!a_pipe && !a_ce0_n && a_ce1 && !a_we_n) |=> (!a_drv_hi && !a_drv_lo)); // R9

    AST_PIPE_DESEL_LATE: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (b_pipe && !(!b_ce0_n && b_ce1)) |=> ##1 (!b_drv_hi && !b_drv_lo)); // R6
endmodule

bind dpram_bytelane dpram_bytelane_chk u_chk (.*);

// File: tb/sim_dpram_bytelane.sv
module sim_dpram_bytelane;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int NW = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic a_pipe, a_ce0_n, a_ce1, a_we_n, a_ub_n, a_lb_n, a_oe_n;
    logic [AW-1:0] a_addr;
    logic [15:0] a_wdata, a_rdata;
    logic a_drv_hi, a_drv_lo;
    logic b_pipe, b_ce0_n, b_ce1, b_we_n, b_ub_n, b_lb_n, b_oe_n;
    logic [AW-1:0] b_addr;
    logic [15:0] b_wdata, b_rdata;
    logic b_drv_hi, b_drv_lo;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] refm [NW];

    dpram_bytelane #(.ADDR_W(AW)) u0 (
        .clk_a(clk), .rst_a_n(rst_n), .a_pipe(a_pipe),
        .a_ce0_n(a_ce0_n), .a_ce1(a_ce1), .a_we_n(a_we_n),
        .a_ub_n(a_ub_n), .a_lb_n(a_lb_n), .a_oe_n(a_oe_n),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .a_drv_hi(a_drv_hi), .a_drv_lo(a_drv_lo),
        .clk_b(clk), .rst_b_n(rst_n), .b_pipe(b_pipe),
        .b_ce0_n(b_ce0_n), .b_ce1(b_ce1), .b_we_n(b_we_n),
        .b_ub_n(b_ub_n), .b_lb_n(b_lb_n), .b_oe_n(b_oe_n),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
        .b_drv_hi(b_drv_hi), .b_drv_lo(b_drv_lo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (R1..R10 run) actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    function automatic logic [15:0] lanes(input logic [15:0] w, input logic ub, input logic lb);
        return {ub ? 8'h00 : w[15:8], lb ? 8'h00 : w[7:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic a_op(input bit sel, input bit wn, input bit ub, input bit lb,
                        input logic [AW-1:0] ad, input logic [15:0] d);
        a_ce0_n = !sel; a_ce1 = sel; a_we_n = wn; a_ub_n = ub; a_lb_n = lb;
        a_addr = ad; a_wdata = d;
    endtask

    task automatic b_op(input bit sel, input bit wn, input bit ub, input bit lb,
                        input logic [AW-1:0] ad, input logic [15:0] d);
        b_ce0_n = !sel; b_ce1 = sel; b_we_n = wn; b_ub_n = ub; b_lb_n = lb;
        b_addr = ad; b_wdata = d;
    endtask

    task automatic upd(input logic [AW-1:0] ad, input logic [15:0] d, input bit ub, input bit lb);
        if (!ub) refm[ad][15:8] = d[15:8];
        if (!lb) refm[ad][7:0] = d[7:0];
    endtask

    initial begin
        logic [AW-1:0] ad, pa, ra;
        logic [15:0] d;
        bit ub, lb;
        void'($urandom(32'd1357));
        a_pipe = 1'b0; b_pipe = 1'b1; a_oe_n = 1'b0; b_oe_n = 1'b0;
        a_op(0, 1, 0, 0, '0, '0);
        b_op(0, 1, 0, 0, '0, '0);
        repeat (3) tick;
        rst_n = 1'b1;
        tick;

        // R1: reset state
        chk({a_drv_hi, a_drv_lo} == 2'b00, "R1 reset A flags", {a_drv_hi, a_drv_lo}, 0);
        chk({b_drv_hi, b_drv_lo} == 2'b00, "R1 reset B flags", {b_drv_hi, b_drv_lo}, 0);

        // fill every word through port A; R9: a write returns no drive
        for (int i = 0; i < NW; i++) begin
            d = 16'($urandom);
            a_op(1, 0, 0, 0, AW'(i), d);
            tick;
            refm[i] = d;
            chk({a_drv_hi, a_drv_lo} == 2'b00, "R9 write cycle A flags", {a_drv_hi, a_drv_lo}, 0);
        end

        // random masked writes, alternating ports
        for (int i = 0; i < 80; i++) begin
            ad = AW'($urandom); d = 16'($urandom);
            ub = 1'($urandom); lb = 1'($urandom);
            if (i % 2 == 0) begin a_op(1, 0, ub, lb, ad, d); b_op(0, 1, 0, 0, '0, '0); end
            else begin b_op(1, 0, ub, lb, ad, d); a_op(0, 1, 0, 0, '0, '0); end
            tick;
            upd(ad, d, ub, lb);
        end
        b_op(0, 1, 0, 0, '0, '0);

        // R2 directed: upper-only write keeps lower lane
        a_op(1, 0, 0, 0, 6'd7, 16'h1234); tick; upd(6'd7, 16'h1234, 0, 0);
        a_op(1, 0, 0, 1, 6'd7, 16'hABCD); tick; upd(6'd7, 16'hABCD, 0, 1);
        a_op(1, 1, 0, 0, 6'd7, 16'h0000); tick;
        chk(a_rdata == 16'hAB34, "R2 upper-only write", a_rdata, 16'hAB34);
        a_op(1, 0, 1, 0, 6'd7, 16'h5566); tick; upd(6'd7, 16'h5566, 1, 0);
        a_op(1, 1, 0, 0, 6'd7, 16'h0000); tick;
        chk(a_rdata == 16'hAB66, "R2 lower-only write", a_rdata, 16'hAB66);

        // R4/R3 flow reads on A with random lane selects
        for (int i = 0; i < 60; i++) begin
            ad = AW'($urandom); ub = 1'($urandom); lb = 1'($urandom);
            a_op(1, 1, ub, lb, ad, '0);
            tick;
            chk(a_rdata == lanes(refm[ad], ub, lb), "R4 flow read data", a_rdata, lanes(refm[ad], ub, lb));
            chk({a_drv_hi, a_drv_lo} == {~ub, ~lb}, "R3 flow lane flags", {a_drv_hi, a_drv_lo}, {~ub, ~lb});
        end

        // R5/R3/R10: B pipelined stream while A reads flow-through
        pa = AW'($urandom);
        b_op(1, 1, 0, 0, pa, '0);
        tick;
        for (int i = 0; i < 60; i++) begin
            ad = AW'($urandom); ra = AW'($urandom);
            ub = 1'($urandom); lb = 1'($urandom);
            b_op(1, 1, ub, lb, ad, '0);
            a_op(1, 1, 0, 0, ra, '0);
            tick;
            chk(b_rdata == lanes(refm[pa], ub, lb), "R5 pipe read data", b_rdata, lanes(refm[pa], ub, lb));
            chk({b_drv_hi, b_drv_lo} == {~ub, ~lb}, "R3 pipe lane flags single stage", {b_drv_hi, b_drv_lo}, {~ub, ~lb});
            chk(a_rdata == refm[ra], "R10 A flow beside B pipe", a_rdata, refm[ra]);
            pa = ad;
        end

        // R6: pipelined deselect and reselect take two edges
        b_op(1, 1, 0, 0, 6'd3, '0); tick; tick;
        b_op(0, 1, 0, 0, 6'd3, '0); tick;
        chk({b_drv_hi, b_drv_lo} == 2'b11, "R6 still driving after deselect", {b_drv_hi, b_drv_lo}, 2'b11);
        chk(b_rdata == refm[3], "R6 data after deselect edge", b_rdata, refm[3]);
        tick;
        chk({b_drv_hi, b_drv_lo} == 2'b00, "R6 quiet second edge", {b_drv_hi, b_drv_lo}, 0);
        b_op(1, 1, 0, 0, 6'd4, '0); tick;
        chk({b_drv_hi, b_drv_lo} == 2'b00, "R6 quiet after reselect", {b_drv_hi, b_drv_lo}, 0);
        tick;
        chk({b_drv_hi, b_drv_lo} == 2'b11, "R6 driving second edge", {b_drv_hi, b_drv_lo}, 2'b11);
        chk(b_rdata == refm[4], "R6 data after reselect", b_rdata, refm[4]);

        // R1: flow-through deselect by either enable
        a_op(1, 1, 0, 0, 6'd2, '0); tick;
        a_ce0_n = 1'b1; tick;
        chk({a_drv_hi, a_drv_lo} == 2'b00, "R1 ce0_n high", {a_drv_hi, a_drv_lo}, 0);
        a_ce0_n = 1'b0; tick;
        chk({a_drv_hi, a_drv_lo} == 2'b11, "R1 reselected", {a_drv_hi, a_drv_lo}, 2'b11);
        a_ce1 = 1'b0; tick;
        chk({a_drv_hi, a_drv_lo} == 2'b00, "R1 ce1 low", {a_drv_hi, a_drv_lo}, 0);

        // R7: asynchronous output enable
        a_op(1, 1, 0, 0, 6'd9, '0); tick;
        #1 a_oe_n = 1'b1;
        #1 chk({a_drv_hi, a_drv_lo} == 2'b00 && a_rdata == 16'h0, "R7 oe high", {a_drv_hi, a_drv_lo}, 0);
        a_oe_n = 1'b0;
        #1 chk(a_rdata == refm[9] && a_drv_hi && a_drv_lo, "R7 oe low again", a_rdata, refm[9]);
        @(negedge clk);

        // R8: cross-port, B writes then A reads
        d = 16'hC3A5;
        b_op(1, 0, 0, 0, 6'd10, d); a_op(0, 1, 0, 0, '0, '0); tick; upd(6'd10, d, 0, 0);
        b_op(0, 1, 0, 0, '0, '0); a_op(1, 1, 0, 0, 6'd10, '0); tick;
        chk(a_rdata == d, "R8 B write seen by A", a_rdata, d);
        // A writes then B reads (pipelined)
        d = 16'h5A3C;
        a_op(1, 0, 0, 0, 6'd11, d); tick; upd(6'd11, d, 0, 0);
        a_op(0, 1, 0, 0, '0, '0); b_op(1, 1, 0, 0, 6'd11, '0); tick; tick;
        chk(b_rdata == d, "R8 A write seen by B", b_rdata, d);

        // R9: pipelined write cycle quiet one edge later
        b_op(1, 0, 0, 0, 6'd12, 16'h7777); tick; upd(6'd12, 16'h7777, 0, 0);
        b_op(1, 1, 0, 0, 6'd12, '0); tick;
        chk({b_drv_hi, b_drv_lo} == 2'b00, "R9 pipe write no drive", {b_drv_hi, b_drv_lo}, 0);
        tick;
        chk(b_rdata == 16'h7777, "R9 pipe read after write", b_rdata, 16'h7777);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule